// File: doc/BRIEF.md
# Timed Burst Transmit Scheduler

This block holds a single 148-bit transmit burst written by a host processor and releases it as a serial bit stream at an exact instant on the air-interface timebase. The block keeps its own timebase: a quarter-bit position counter that advances on each `qb_tick` strobe and a frame counter that advances each time the quarter-bit position wraps. The host can preset the frame counter.

The host writes the burst as 16-bit words, then writes a target time and an arm bit into the event registers. When the running frame number and quarter-bit position equal the target on a tick, the block starts streaming. It sends each burst bit for four ticks with a valid strobe. When the last bit has gone, it raises a completion interrupt. The interrupt stays set until the host clears it.

Writes to the burst words during a transmission are dropped. Each such write sets a sticky error flag. Phase shaping and conversion to analog happen downstream.

Top module: `burst_tx_sched`

## Requirements
- R1: `qb_count` runs from 0 to 4999, advancing by one on each edge where `qb_tick` is high. It wraps from 4999 to 0, and `frame_count` advances by one on that wrap.
- R2: `frame_count` wraps from 2715647 to 0. A write to address 14 loads `frame_count` with {`host_wdata`[5:0], the value last written to address 13} and sets `qb_count` to 0 at the same edge. This preset takes priority over the tick.
- R3: Burst word address k (0 to 9) holds burst bits 16k to 16k+15, with `host_wdata` bit j going to burst bit 16k+j. Bits above 147 are stored but never sent. Bit 0 is sent first, then in ascending order.
- R4: The event registers are as follows. Address 10 bits [12:0] hold the target quarter-bit position. Address 11 holds target frame bits [15:0]. Address 12 bits [5:0] hold target frame bits [21:16], and address 12 bit 15 is the transmit arm bit: 1 arms, 0 disarms.
- R5: A transmission starts at an edge where the block is armed, idle and ticking, and `qb_count` and `frame_count` equal the target. From the next cycle `tx_valid` is high, and the counters read the target position plus one tick. Starting clears the arm.
- R6: Each burst bit is held on `tx_bit` for exactly 4 ticks. `tx_valid` stays high without a break for exactly 592 ticks.
- R7: An armed target that is already behind the timebase does not fire at once or within the following frame. It fires only on an exact match.
- R8: `irq_done` rises at the same edge where `tx_valid` falls. It stays high until a write to address 15 with bit 0 set.
- R9: A burst-word write while `tx_valid` is high leaves the stored burst unchanged and sets `err_busy_wr`. The flag stays set until a write to address 15 with bit 1 set.
- R10: Just after reset, `tx_valid`, `tx_bit`, `irq_done`, `err_busy_wr`, `qb_count` and `frame_count` are all 0.
- R11: Writing address 12 with bit 15 at 0 cancels a pending event, so no transmission follows at its target time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qb_tick | input | 1 | Quarter-bit timebase strobe |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 16 | Host write data |
| tx_bit | output | 1 | Serial burst bit |
| tx_valid | output | 1 | High for the whole burst window |
| irq_done | output | 1 | Sticky completion interrupt |
| err_busy_wr | output | 1 | Sticky flag for a burst write during transmission |
| qb_count | output | 13 | Current quarter-bit position |
| frame_count | output | 22 | Current frame number |

## Verification
The stimulus holds `qb_tick` high, so each tick is one clock and the timing is easy to count. A preset lands at one edge. With target position T, the match happens T+1 edges after the preset, and `tx_valid` is checked low for the T samples before that and high at the sample after the match edge. Burst bit n is then checked in each of samples 4n to 4n+3 counted from the start sample, and the sample that follows the 592nd must show `tx_valid` low and `irq_done` high. Counter checks follow the same rule: they are sampled 4999 and 5000 edges after a preset. All samples are taken on the falling clock edge, between active edges.

// File: rtl/burst_tx_pkg.sv
package burst_tx_pkg;
  localparam int HOST_W = 16;
  localparam int ADDR_W = 4;
  localparam int BURST_WORDS = 10;

  localparam logic [ADDR_W-1:0] A_EVT_QB  = 4'd10;
  localparam logic [ADDR_W-1:0] A_EVT_FLO = 4'd11;
  localparam logic [ADDR_W-1:0] A_EVT_FHI = 4'd12;
  localparam logic [ADDR_W-1:0] A_PRE_LO  = 4'd13;
  localparam logic [ADDR_W-1:0] A_PRE_HI  = 4'd14;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'd15;

  localparam int CTL_ARM_BIT = 15;
  localparam int STS_IRQ_BIT = 0;
  localparam int STS_ERR_BIT = 1;
endpackage

// File: rtl/btx_timebase.sv
module btx_timebase #(
  parameter int QB_PER_FRAME = 5000,
  parameter int FRAME_MOD    = 2715648,
  parameter int QB_W         = 13,
  parameter int FN_W         = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            preset_we,
  input  logic [FN_W-1:0] preset_fn,
  output logic [QB_W-1:0] qb,
  output logic [FN_W-1:0] fn
);
  localparam logic [QB_W-1:0] QB_LAST = QB_W'(QB_PER_FRAME - 1);
  localparam logic [FN_W-1:0] FN_LAST = FN_W'(FRAME_MOD - 1);

  logic [QB_W-1:0] qb_q, qb_nx;
  logic [FN_W-1:0] fn_q, fn_nx;

  always_comb begin
    qb_nx = qb_q;
    fn_nx = fn_q;
    if (preset_we) begin
      qb_nx = '0;
      fn_nx = preset_fn;
    end else if (tick) begin
      if (qb_q == QB_LAST) begin
        qb_nx = '0;
        fn_nx = (fn_q == FN_LAST) ? '0 : fn_q + 1'b1;
      end else begin
        qb_nx = qb_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qb_q <= '0;
      fn_q <= '0;
    end else begin
      qb_q <= qb_nx;
      fn_q <= fn_nx;
    end
  end

  assign qb = qb_q;
  assign fn = fn_q;
endmodule

// File: rtl/btx_burst_store.sv
module btx_burst_store #(
  parameter int HOST_W = 16,
  parameter int WORDS  = 10,
  parameter int WSEL_W = 4,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WSEL_W-1:0] wsel,
  input  logic [HOST_W-1:0] wdata,
  input  logic [IDX_W-1:0]  bit_sel,
  output logic              bit_out
);
  localparam int FLAT_W = WORDS * HOST_W;

  logic [FLAT_W-1:0] flat;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic [HOST_W-1:0] word_q;
    logic              word_en;
    assign word_en = wr_en && (wsel == WSEL_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= wdata;
    end
    assign flat[k*HOST_W +: HOST_W] = word_q;
  end

  assign bit_out = flat[bit_sel];
endmodule

// File: rtl/btx_sequencer.sv
module btx_sequencer #(
  parameter int QB_W          = 13,
  parameter int FN_W          = 22,
  parameter int HOST_W        = 16,
  parameter int BURST_BITS    = 148,
  parameter int TICKS_PER_BIT = 4,
  parameter int IDX_W         = 8,
  parameter int ARM_BIT       = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [QB_W-1:0]   qb,
  input  logic [FN_W-1:0]   fn,
  input  logic              evt_qb_we,
  input  logic              evt_flo_we,
  input  logic              evt_fhi_we,
  input  logic [HOST_W-1:0] wdata,
  output logic              busy,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              done,
  output logic              armed,
  output logic [QB_W-1:0]   tgt_qb,
  output logic [FN_W-1:0]   tgt_fn
);
  localparam int PH_W  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int FH_W  = FN_W - HOST_W;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(TICKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BURST_BITS - 1);

  logic [QB_W-1:0]  tqb_q, tqb_nx;
  logic [FN_W-1:0]  tfn_q, tfn_nx;
  logic             arm_q, arm_nx;
  logic             busy_q, busy_nx;
  logic [IDX_W-1:0] idx_q, idx_nx;
  logic [PH_W-1:0]  ph_q, ph_nx;
  logic             hit;

  assign hit = arm_q && tick && !busy_q && (qb == tqb_q) && (fn == tfn_q);

  always_comb begin
    tqb_nx  = tqb_q;
    tfn_nx  = tfn_q;
    arm_nx  = arm_q;
    busy_nx = busy_q;
    idx_nx  = idx_q;
    ph_nx   = ph_q;
    done    = 1'b0;
    if (busy_q && tick) begin
      if (ph_q == PH_LAST) begin
        ph_nx = '0;
        if (idx_q == IDX_LAST) begin
          busy_nx = 1'b0;
          idx_nx  = '0;
          done    = 1'b1;
        end else begin
          idx_nx = idx_q + 1'b1;
        end
      end else begin
        ph_nx = ph_q + 1'b1;
      end
    end else if (hit) begin
      busy_nx = 1'b1;
      idx_nx  = '0;
      ph_nx   = '0;
      arm_nx  = 1'b0;
    end
    if (evt_qb_we)  tqb_nx = wdata[QB_W-1:0];
    if (evt_flo_we) tfn_nx[HOST_W-1:0] = wdata;
    if (evt_fhi_we) begin
      tfn_nx[FN_W-1:HOST_W] = wdata[FH_W-1:0];
      arm_nx = wdata[ARM_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tqb_q  <= '0;
      tfn_q  <= '0;
      arm_q  <= 1'b0;
      busy_q <= 1'b0;
      idx_q  <= '0;
      ph_q   <= '0;
    end else begin
      tqb_q  <= tqb_nx;
      tfn_q  <= tfn_nx;
      arm_q  <= arm_nx;
      busy_q <= busy_nx;
      idx_q  <= idx_nx;
      ph_q   <= ph_nx;
    end
  end

  assign busy    = busy_q;
  assign bit_idx = idx_q;
  assign armed   = arm_q;
  assign tgt_qb  = tqb_q;
  assign tgt_fn  = tfn_q;
endmodule

// File: rtl/burst_tx_sched.sv
module burst_tx_sched
  import burst_tx_pkg::*;
#(
  parameter  int BURST_BITS    = 148,
  parameter  int TICKS_PER_BIT = 4,
  parameter  int QB_PER_FRAME  = 5000,
  parameter  int FRAME_MOD     = 2715648,
  localparam int QB_W          = $clog2(QB_PER_FRAME),
  localparam int FN_W          = $clog2(FRAME_MOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qb_tick,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic              tx_bit,
  output logic              tx_valid,
  output logic              irq_done,
  output logic              err_busy_wr,
  output logic [QB_W-1:0]   qb_count,
  output logic [FN_W-1:0]   frame_count
);
  localparam int IDX_W  = $clog2(BURST_BITS);
  localparam int WSEL_W = ADDR_W;
  localparam int FH_W   = FN_W - HOST_W;

  logic             busy, done, armed, store_bit;
  logic [IDX_W-1:0] bit_idx;
  logic [QB_W-1:0]  evt_qb_w;
  logic [FN_W-1:0]  evt_fn_w;
  logic             burst_hit, burst_we, clr_wr;
  logic             irq_q, irq_nx, err_q, err_nx;
  logic [HOST_W-1:0] pre_lo_q, pre_lo_nx;

  assign burst_hit = host_we && (host_addr < ADDR_W'(BURST_WORDS));
  assign burst_we  = burst_hit && !busy;
  assign clr_wr    = host_we && (host_addr == A_STATUS);

  btx_timebase #(
    .QB_PER_FRAME(QB_PER_FRAME), .FRAME_MOD(FRAME_MOD), .QB_W(QB_W), .FN_W(FN_W)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(qb_tick),
    .preset_we(host_we && (host_addr == A_PRE_HI)),
    .preset_fn({host_wdata[FH_W-1:0], pre_lo_q}),
    .qb(qb_count), .fn(frame_count)
  );

  btx_burst_store #(
    .HOST_W(HOST_W), .WORDS(BURST_WORDS), .WSEL_W(WSEL_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(burst_we), .wsel(host_addr),
    .wdata(host_wdata), .bit_sel(bit_idx), .bit_out(store_bit)
  );

  btx_sequencer #(
    .QB_W(QB_W), .FN_W(FN_W), .HOST_W(HOST_W), .BURST_BITS(BURST_BITS),
    .TICKS_PER_BIT(TICKS_PER_BIT), .IDX_W(IDX_W), .ARM_BIT(CTL_ARM_BIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(qb_tick), .qb(qb_count), .fn(frame_count),
    .evt_qb_we(host_we && (host_addr == A_EVT_QB)),
    .evt_flo_we(host_we && (host_addr == A_EVT_FLO)),
    .evt_fhi_we(host_we && (host_addr == A_EVT_FHI)),
    .wdata(host_wdata), .busy(busy), .bit_idx(bit_idx), .done(done),
    .armed(armed), .tgt_qb(evt_qb_w), .tgt_fn(evt_fn_w)
  );

  always_comb begin
    irq_nx    = done | (irq_q & ~(clr_wr & host_wdata[STS_IRQ_BIT]));
    err_nx    = (burst_hit & busy) | (err_q & ~(clr_wr & host_wdata[STS_ERR_BIT]));
    pre_lo_nx = (host_we && (host_addr == A_PRE_LO)) ? host_wdata : pre_lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
      pre_lo_q <= '0;
    end else begin
      irq_q    <= irq_nx;
      err_q    <= err_nx;
      pre_lo_q <= pre_lo_nx;
    end
  end

  assign tx_valid    = busy;
  assign tx_bit      = busy & store_bit;
  assign irq_done    = irq_q;
  assign err_busy_wr = err_q;
endmodule

// File: rtl/burst_tx_checker.sv
module burst_tx_checker
  import burst_tx_pkg::*;
#(
  parameter int BURST_BITS    = 148,
  parameter int TICKS_PER_BIT = 4,
  parameter int QB_PER_FRAME  = 5000,
  parameter int QB_W          = 13,
  parameter int FN_W          = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [HOST_W-1:0] host_wdata,
  input logic              tx_valid,
  input logic              irq,
  input logic              err,
  input logic [QB_W-1:0]   qb,
  input logic [FN_W-1:0]   fn,
  input logic              armed,
  input logic [QB_W-1:0]   tgt_qb,
  input logic [FN_W-1:0]   tgt_fn
);
  localparam int LEN   = BURST_BITS * TICKS_PER_BIT;
  localparam int LEN_W = $clog2(LEN + 1);
  localparam logic [QB_W-1:0] QB_LAST = QB_W'(QB_PER_FRAME - 1);

  logic [LEN_W-1:0] run_q;
  logic clr_irq, clr_err, preset, burst_wr;

  assign clr_irq  = host_we && host_addr == A_STATUS && host_wdata[STS_IRQ_BIT];
  assign clr_err  = host_we && host_addr == A_STATUS && host_wdata[STS_ERR_BIT];
  assign preset   = host_we && host_addr == A_PRE_HI;
  assign burst_wr = host_we && host_addr < ADDR_W'(BURST_WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '0;
    else if (!tx_valid)        run_q <= '0;
    else if (tick)             run_q <= run_q + 1'b1;
  end

  p_qb_range_r1: assert property (@(posedge clk) disable iff (!rst_n) qb <= QB_LAST);
  p_qb_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !preset && qb != QB_LAST |=> qb == $past(qb) + 1'b1);
  p_start_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(armed) && $past(tick) && $past(qb) == $past(tgt_qb)
                        && $past(fn) == $past(tgt_fn));
  p_run_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_valid) |-> run_q == LEN_W'(LEN));
  p_irq_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_valid) |-> irq);
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_irq |=> irq);
  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_wr && tx_valid |=> err);
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clr_err |=> err);
endmodule

bind burst_tx_sched burst_tx_checker #(
  .BURST_BITS(BURST_BITS), .TICKS_PER_BIT(TICKS_PER_BIT),
  .QB_PER_FRAME(QB_PER_FRAME), .QB_W(QB_W), .FN_W(FN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(qb_tick), .host_we(host_we),
  .host_addr(host_addr), .host_wdata(host_wdata), .tx_valid(tx_valid),
  .irq(irq_done), .err(err_busy_wr), .qb(qb_count), .fn(frame_count),
  .armed(armed), .tgt_qb(evt_qb_w), .tgt_fn(evt_fn_w)
);

// File: tb/tb_burst_tx_sched.sv
module tb_burst_tx_sched;
  localparam int QBF = 5000;
  localparam int FMOD = 2715648;

  logic        clk, rst_n, qb_tick, host_we;
  logic [3:0]  host_addr;
  logic [15:0] host_wdata;
  logic        tx_bit, tx_valid, irq_done, err_busy_wr;
  logic [12:0] qb_count;
  logic [21:0] frame_count;

  int checks = 0;
  int fails  = 0;

  burst_tx_sched dut (
    .clk(clk), .rst_n(rst_n), .qb_tick(qb_tick), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .tx_bit(tx_bit),
    .tx_valid(tx_valid), .irq_done(irq_done), .err_busy_wr(err_busy_wr),
    .qb_count(qb_count), .frame_count(frame_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Loads a burst, arms target (F,T), presets the timebase to frame F, then
  // checks start time, every bit and the end of the window.
  task automatic run_burst(input logic [147:0] pat, input int T, input int F,
                           input bit inject, input string tag);
    logic [159:0] ext;
    int early, mism, efn;
    ext = {12'hA5C, pat};
    for (int k = 0; k < 10; k++) wr(4'(k), ext[16*k +: 16]);
    wr(4'd10, 16'(T));
    wr(4'd11, F[15:0]);
    wr(4'd12, 16'h8000 | 16'(F[21:16]));
    wr(4'd13, F[15:0]);
    wr(4'd14, 16'(F[21:16]));
    early = 0;
    for (int k = 0; k < T; k++) begin
      @(negedge clk);
      if (tx_valid) early++;
    end
    chk(early == 0, "R5", {tag, " early valid samples"}, early, 0);
    @(negedge clk);
    chk(tx_valid == 1'b1, "R5", {tag, " valid at match+1"}, tx_valid, 1);
    chk(qb_count == 13'((T + 1) % QBF), "R5", {tag, " qb at start"}, qb_count, (T + 1) % QBF);
    efn = (T == QBF - 1) ? (F + 1) % FMOD : F;
    chk(frame_count == 22'(efn), "R5", {tag, " frame at start"}, frame_count, efn);
    mism = 0;
    for (int i = 0; i < 592; i++) begin
      if (!tx_valid || tx_bit != pat[i/4]) mism++;
      if (inject && i == 40) begin
        host_we = 1'b1; host_addr = 4'd0; host_wdata = ~ext[15:0];
      end
      if (inject && i == 41) host_we = 1'b0;
      if (i != 591) @(negedge clk);
    end
    chk(mism == 0, "R3", {tag, " bit stream mismatches (R6 hold 4 ticks)"}, mism, 0);
    @(negedge clk);
    chk(tx_valid == 1'b0, "R6", {tag, " valid drops after 592 ticks"}, tx_valid, 0);
    chk(irq_done == 1'b1, "R8", {tag, " irq at end"}, irq_done, 1);
  endtask

  initial begin
    int seen;
    logic [147:0] pa, pb, pc;
    logic [31:0] lf;
    rst_n = 1'b0; qb_tick = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(tx_valid == 0 && tx_bit == 0, "R10", "tx outputs after reset", {tx_valid, tx_bit}, 0);
    chk(irq_done == 0 && err_busy_wr == 0, "R10", "flags after reset", {irq_done, err_busy_wr}, 0);
    chk(qb_count == 0 && frame_count == 0, "R10", "counters after reset", qb_count + frame_count, 0);
    qb_tick = 1'b1;

    // R1 / R2 counter sweep
    wr(4'd13, 16'd5); wr(4'd14, 16'd0);
    wait_n(4999);
    chk(qb_count == 4999, "R1", "qb at last position", qb_count, 4999);
    chk(frame_count == 5, "R2", "frame after preset", frame_count, 5);
    @(negedge clk);
    chk(qb_count == 0, "R1", "qb wraps", qb_count, 0);
    chk(frame_count == 6, "R1", "frame advances on wrap", frame_count, 6);
    wr(4'd13, 16'(FMOD - 1)); wr(4'd14, 16'((FMOD - 1) >> 16));
    wait_n(5000);
    chk(frame_count == 0 && qb_count == 0, "R2", "hyperframe wrap", frame_count, 0);

    // Burst A: alternating, R3 R4 R5 R6 R8
    pa = {74{2'b10}};
    run_burst(pa, 20, 100, 1'b0, "burstA");
    wait_n(30);
    chk(irq_done == 1'b1, "R8", "irq held until cleared", irq_done, 1);
    chk(err_busy_wr == 1'b0, "R9", "no error on clean run", err_busy_wr, 0);
    wr(4'd15, 16'h0001);
    chk(irq_done == 1'b0, "R8", "irq cleared by status write", irq_done, 0);

    // Burst B: pattern, last position, across hyperframe wrap, write while busy
    for (int i = 0; i < 148; i++) pb[i] = (i % 3 == 0);
    run_burst(pb, QBF - 1, FMOD - 1, 1'b1, "burstB");
    chk(err_busy_wr == 1'b1, "R9", "error after busy write", err_busy_wr, 1);
    wr(4'd15, 16'h0001);
    chk(err_busy_wr == 1'b1, "R9", "error survives irq clear", err_busy_wr, 1);
    wr(4'd15, 16'h0002);
    chk(err_busy_wr == 1'b0, "R9", "error cleared", err_busy_wr, 0);

    // Burst C: pseudo-random, target position 0
    lf = 32'hACE1_1234;
    for (int i = 0; i < 148; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      pc[i] = lf[0];
    end
    run_burst(pc, 0, 7, 1'b0, "burstC");
    wr(4'd15, 16'h0003);

    // R7 target already passed
    wr(4'd13, 16'd50); wr(4'd14, 16'd0);
    wait_n(100);
    wr(4'd10, 16'd10); wr(4'd11, 16'd50); wr(4'd12, 16'h8000);
    seen = 0;
    for (int i = 0; i < 5200; i++) begin
      @(negedge clk);
      if (tx_valid) seen++;
    end
    chk(seen == 0, "R7", "passed target does not fire", seen, 0);

    // R11 disarm cancels
    wr(4'd10, 16'd30); wr(4'd11, 16'd60); wr(4'd12, 16'h8000);
    wr(4'd12, 16'h0000);
    wr(4'd13, 16'd60); wr(4'd14, 16'd0);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_valid) seen++;
    end
    chk(seen == 0, "R11", "disarmed event silent", seen, 0);
    chk(irq_done == 1'b0, "R11", "no irq after disarm", irq_done, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule